// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or discarded on the strength of its destination address. The receive path streams the leading octets of the frame into the block one per valid cycle and presents the frame length alongside the first octet. Once six destination octets have arrived, the block raises a verdict strobe for one cycle with an accept flag.

Software programs the filter through 32-bit register writes. There are two exact-match unicast slots, a broadcast enable, and a 64-bit hash table for group addresses. The hash folds the 48-bit destination into a 6-bit index, and that index picks one table bit. Through a control bit the hash can also be applied to individual addresses. The block takes a copy of its configuration when a frame starts, so a write made while a frame is in flight affects only later frames.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset every unicast enable, the broadcast enable, the individual-hash enable and all 64 table bits are 0, so every frame gets a verdict with accept low until software programs the block.
- R2: Slot 0 uses write offsets 0x00 (low) and 0x04 (high), and slot 1 uses 0x08 and 0x0C. The low register carries destination octets 0..3, with octet 0 in bits 7:0, octet 1 in bits 15:8, and so on. The high register carries octet 4 in bits 7:0 and octet 5 in bits 15:8. Writes to any other offset leave the configuration unchanged.
- R3: The control register is at offset 0x1C. Bit 0 enables slot 0 and bit 1 enables slot 1. An enabled slot accepts a frame whose six destination octets all equal the programmed ones, and a disabled slot never accepts.
- R4: With control bit 3 set, a destination of all ones is accepted. With the bit clear, broadcast alone gives no accept.
- R5: The hash index is formed from the destination read as a 48-bit value with octet 0 in bits 7:0. That value is cut into eight 6-bit fields, and the fields are XORed together. Table bits 0..31 are written at offset 0x10 and bits 32..63 at offset 0x14, with index i selecting bit i mod 32 of the matching register. The frame is accepted when the selected bit is 1.
- R6: With control bit 2 clear, a destination whose octet 0 bit 0 is 0 never hits the hash. With the bit set, such destinations use the hash like group destinations.
- R7: A frame whose length is below 12 gets accept low whatever its destination. A length of exactly 12 is evaluated normally.
- R8: The verdict strobe goes high for exactly one cycle, on the cycle after the clock edge that takes the sixth destination octet. Cycles with octet-valid low are not counted. Further octets of the same frame produce no verdict.
- R9: The configuration used for a frame is the one in force when its first octet is taken. A register write made during the frame changes only later frames.
- R10: An octet marked first always starts a new frame at octet 0. A partial frame it interrupts gets no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 6 | Register byte offset |
| cfg_wr_data | input | 32 | Register write data |
| oct_valid | input | 1 | Octet present on oct_data |
| oct_first | input | 1 | Octet is the first of a frame |
| oct_data | input | 8 | Frame octet |
| frame_len | input | 16 | Frame length in bytes, taken with the first octet |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | Frame accepted, valid with verdict_valid |

## Verification
The bench goes through all 64 table indices one at a time and then runs 512 varied destinations against a dense table, with the individual-hash bit both clear and set. A design that folded octets in the wrong order or misplaced a field would light the wrong table bit, and one that ignored the group-bit rule would pass individual addresses. It also probes the length boundary at 11 and 12, where an off-by-one comparison would flip the verdict. Other cases are a control write made in the middle of a frame, which a design without a configuration snapshot would apply at once, gaps in the octet stream and trailing octets, which a loose counter would mistime or double-strobe on, and a frame restarted by a new first octet. A one-bit change in the last octet checks that the exact match covers all 48 bits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_OCTETS = 6;
    localparam int ADDR_BITS   = ADDR_OCTETS * 8;
    localparam int HASH_W      = 6;
    localparam int TBL_BITS    = 1 << HASH_W;
    localparam int REG_DW      = 32;
    localparam int REG_AW      = 6;
    localparam int NUM_UC      = 2;
    localparam int UC_STRIDE   = 8;

    localparam logic [REG_AW-1:0] OFS_TBL_LO = 6'h10;
    localparam logic [REG_AW-1:0] OFS_TBL_HI = 6'h14;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 6'h1C;

    localparam int CTRL_INDIV_BIT = 2;
    localparam int CTRL_BCAST_BIT = 3;

    typedef struct packed {
        logic [NUM_UC-1:0][ADDR_BITS-1:0] ma;
        logic [NUM_UC-1:0]                uc_en;
        logic [TBL_BITS-1:0]              tbl;
        logic                             hash_indiv;
        logic                             bcast_en;
    } filt_cfg_t;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [REG_DW-1:0] wr_data_i,
    output filt_cfg_t         cfg_o
);

    localparam int HI_BITS  = ADDR_BITS - REG_DW;
    localparam int TBL_HI_W = TBL_BITS - REG_DW;

    filt_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int s = 0; s < NUM_UC; s++) begin
                if (wr_addr_i == REG_AW'(UC_STRIDE * s))
                    cfg_d.ma[s][REG_DW-1:0] = wr_data_i;
                if (wr_addr_i == REG_AW'(UC_STRIDE * s + 4))
                    cfg_d.ma[s][ADDR_BITS-1:REG_DW] = wr_data_i[HI_BITS-1:0];
            end
            if (wr_addr_i == OFS_TBL_LO)
                cfg_d.tbl[REG_DW-1:0] = wr_data_i;
            if (wr_addr_i == OFS_TBL_HI)
                cfg_d.tbl[TBL_BITS-1:REG_DW] = wr_data_i[TBL_HI_W-1:0];
            if (wr_addr_i == OFS_CTRL) begin
                cfg_d.uc_en      = wr_data_i[NUM_UC-1:0];
                cfg_d.hash_indiv = wr_data_i[CTRL_INDIV_BIT];
                cfg_d.bcast_en   = wr_data_i[CTRL_BCAST_BIT];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R2: without a write strobe the live configuration holds
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cfg_o));

endmodule

// File: rtl/rxf_dest_capture.sv
module rxf_dest_capture
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 oct_valid_i,
    input  logic                 oct_first_i,
    input  logic [7:0]           oct_data_i,
    input  logic [LEN_W-1:0]     frame_len_i,
    output logic [ADDR_BITS-1:0] dest_o,
    output logic                 short_o,
    output logic                 done_o
);

    localparam int CNT_W = $clog2(ADDR_OCTETS + 1);

    typedef struct packed {
        logic                 active;
        logic [CNT_W-1:0]     cnt;
        logic [ADDR_BITS-1:0] dest;
        logic                 short_f;
        logic                 done;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (oct_valid_i) begin
            if (oct_first_i) begin
                st_d.active    = 1'b1;
                st_d.cnt       = CNT_W'(1);
                st_d.dest      = '0;
                st_d.dest[7:0] = oct_data_i;
                st_d.short_f   = (frame_len_i < LEN_W'(MIN_LEN));
            end else if (st_q.active && (st_q.cnt < CNT_W'(ADDR_OCTETS))) begin
                st_d.dest[int'(st_q.cnt)*8 +: 8] = oct_data_i;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(ADDR_OCTETS - 1))
                    st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dest_o  = st_q.dest;
    assign short_o = st_q.short_f;
    assign done_o  = st_q.done;

    // R8: the octet counter never runs past the destination length
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(ADDR_OCTETS));

    // R10: a first octet always leaves exactly one octet collected
    a_r10_first_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid_i && oct_first_i) |=> (st_q.cnt == CNT_W'(1)) && !done_o);

endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold #(
    parameter int IN_W  = 48,
    parameter int OUT_W = 6
) (
    input  logic [IN_W-1:0]  value_i,
    output logic [OUT_W-1:0] index_o
);

    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int k = b; k < IN_W; k += OUT_W)
                acc ^= value_i[k];
        end
        assign index_o[b] = acc;
    end

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  filt_cfg_t            cfg_i,
    input  logic [ADDR_BITS-1:0] dest_i,
    input  logic [HASH_W-1:0]    hash_idx_i,
    output logic                 hit_o
);

    logic [NUM_UC-1:0] uc_hit;
    logic              bcast_hit;
    logic              hash_hit;
    logic              group_dest;

    for (genvar s = 0; s < NUM_UC; s++) begin : g_uc
        assign uc_hit[s] = cfg_i.uc_en[s] && (dest_i == cfg_i.ma[s]);
    end

    assign group_dest = dest_i[0];
    assign bcast_hit  = cfg_i.bcast_en && (&dest_i);
    assign hash_hit   = cfg_i.tbl[hash_idx_i] && (cfg_i.hash_indiv || group_dest);
    assign hit_o      = (|uc_hit) || bcast_hit || hash_hit;

    // R6: individual destinations stay out of the hash unless enabled
    a_r6_indiv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.hash_indiv && !dest_i[0]) |-> !hash_hit);

    // R4: broadcast cannot pass when its enable and every other source are off
    a_r4_bcast_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.bcast_en && (cfg_i.uc_en == '0) && (cfg_i.tbl == '0)) |-> !hit_o);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_wr_addr,
    input  logic [REG_DW-1:0] cfg_wr_data,
    input  logic              oct_valid,
    input  logic              oct_first,
    input  logic [7:0]        oct_data,
    input  logic [LEN_W-1:0]  frame_len,
    output logic              verdict_valid,
    output logic              verdict_accept
);

    filt_cfg_t            live_cfg;
    filt_cfg_t            snap_d, snap_q;
    logic [ADDR_BITS-1:0] dest;
    logic                 short_f;
    logic                 done;
    logic [HASH_W-1:0]    hash_idx;
    logic                 hit;
    logic                 frame_start;

    rxf_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en),
        .wr_addr_i (cfg_wr_addr),
        .wr_data_i (cfg_wr_data),
        .cfg_o     (live_cfg)
    );

    rxf_dest_capture #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .oct_valid_i (oct_valid),
        .oct_first_i (oct_first),
        .oct_data_i  (oct_data),
        .frame_len_i (frame_len),
        .dest_o      (dest),
        .short_o     (short_f),
        .done_o      (done)
    );

    rxf_hash_fold #(
        .IN_W  (ADDR_BITS),
        .OUT_W (HASH_W)
    ) u_hash (
        .value_i (dest),
        .index_o (hash_idx)
    );

    rxf_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_i      (snap_q),
        .dest_i     (dest),
        .hash_idx_i (hash_idx),
        .hit_o      (hit)
    );

    assign frame_start = oct_valid && oct_first;

    always_comb begin
        snap_d = snap_q;
        if (frame_start) snap_d = live_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign verdict_valid  = done;
    assign verdict_accept = done && !short_f && hit;

    // R8: the verdict strobe never lasts two cycles
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |=> !verdict_valid);

    // R8: no verdict in the cycle right after a first octet
    a_r8_no_early_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !verdict_valid);

    // R7: a short frame is never accepted
    a_r7_short_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict_valid && short_f) |-> !verdict_accept);

    // R9: the per-frame configuration only moves at a frame start
    a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(snap_q));

endmodule

// File: tb/rx_dest_filter_tb_top.sv
module rx_dest_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [5:0]  cfg_wr_addr;
    logic [31:0] cfg_wr_data;
    logic        oct_valid;
    logic        oct_first;
    logic [7:0]  oct_data;
    logic [15:0] frame_len;
    logic        verdict_valid;
    logic        verdict_accept;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [47:0] m_ma0, m_ma1;
    logic [63:0] m_tbl;
    logic [3:0]  m_ctrl;

    always #10 clk = ~clk;

    rx_dest_filter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_wr_en      (cfg_wr_en),
        .cfg_wr_addr    (cfg_wr_addr),
        .cfg_wr_data    (cfg_wr_data),
        .oct_valid      (oct_valid),
        .oct_first      (oct_first),
        .oct_data       (oct_data),
        .frame_len      (frame_len),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void mirror_write(input logic [5:0] a, input logic [31:0] d);
        case (a)
            6'h00: m_ma0[31:0]  = d;
            6'h04: m_ma0[47:32] = d[15:0];
            6'h08: m_ma1[31:0]  = d;
            6'h0C: m_ma1[47:32] = d[15:0];
            6'h10: m_tbl[31:0]  = d;
            6'h14: m_tbl[63:32] = d;
            6'h1C: m_ctrl       = d[3:0];
            default: ;
        endcase
    endfunction

    function automatic logic [5:0] fold(input logic [47:0] v);
        logic [5:0] h = 6'd0;
        for (int f = 0; f < 8; f++) h ^= 6'((v >> (6 * f)) & 48'h3F);
        return h;
    endfunction

    function automatic bit expect_accept(input logic [47:0] dst, input logic [15:0] len);
        bit hh;
        if (len < 16'd12) return 0;
        if (m_ctrl[0] && dst == m_ma0) return 1;
        if (m_ctrl[1] && dst == m_ma1) return 1;
        if (m_ctrl[3] && dst == {48{1'b1}}) return 1;
        hh = m_tbl[fold(dst)];
        return hh && (m_ctrl[2] || dst[0]);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        mirror_write(a, d);
    endtask

    task automatic set_ma(input int slot, input logic [47:0] v);
        wr(6'(slot * 8), v[31:0]);
        wr(6'(slot * 8 + 4), {16'h0, v[47:32]});
    endtask

    // frame with optional gaps and an optional register write alongside octet 3
    task automatic send(input logic [47:0] dst, input logic [15:0] len, input string req,
                        input bit gaps, input bit do_wr, input logic [5:0] wa, input logic [31:0] wd);
        bit exp;
        exp = expect_accept(dst, len);
        for (int i = 0; i < 6; i++) begin
            if (gaps && i > 0) begin
                @(negedge clk);
                oct_valid = 1'b0;
                check(verdict_valid == 1'b0, "R8 gap", 64'(verdict_valid), 64'd0);
            end
            @(negedge clk);
            oct_valid = 1'b1;
            oct_first = (i == 0);
            oct_data  = dst[8*i +: 8];
            frame_len = (i == 0) ? len : 16'hXXXX;
            cfg_wr_en = do_wr && (i == 3);
            cfg_wr_addr = wa; cfg_wr_data = wd;
        end
        @(negedge clk);
        oct_valid = 1'b0; oct_first = 1'b0; cfg_wr_en = 1'b0;
        if (do_wr) mirror_write(wa, wd);
        check(verdict_valid == 1'b1, "R8 strobe", 64'(verdict_valid), 64'd1);
        check(verdict_accept == exp, req, 64'(verdict_accept), 64'(exp));
        @(negedge clk);
        check(verdict_valid == 1'b0, "R8 one cycle", 64'(verdict_valid), 64'd0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [47:0] a_addr, b_addr, d;
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_addr = '0; cfg_wr_data = '0;
        oct_valid = 1'b0; oct_first = 1'b0; oct_data = '0; frame_len = '0;
        m_ma0 = '0; m_ma1 = '0; m_tbl = '0; m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(verdict_valid == 1'b0, "R1 reset strobe", 64'(verdict_valid), 64'd0);

        // R1: nothing programmed, everything dropped
        send({48{1'b1}}, 16'd64, "R1 bcast dropped", 0, 0, 6'h0, 32'h0);
        send(48'h0000_0000_0001, 16'd64, "R1 group dropped", 0, 0, 6'h0, 32'h0);
        send(48'h0000_0000_0000, 16'd64, "R1 zero dropped", 0, 0, 6'h0, 32'h0);

        // R2 R3: unicast slots
        a_addr = 48'h5E4D_3C2B_1A08;
        b_addr = 48'hF0E1_D2C3_B4A6;
        set_ma(0, a_addr);
        set_ma(1, b_addr);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h1C, 32'h1);
        send(a_addr, 16'd64, "R3 slot0 match", 0, 0, 6'h0, 32'h0);
        send(a_addr ^ 48'h0100_0000_0000, 16'd64, "R3 octet5 mismatch", 0, 0, 6'h0, 32'h0);
        send(b_addr, 16'd64, "R3 slot1 disabled", 0, 0, 6'h0, 32'h0);
        wr(6'h1C, 32'h2);
        send(b_addr, 16'd64, "R3 slot1 match", 0, 0, 6'h0, 32'h0);
        send(a_addr, 16'd64, "R3 slot0 disabled", 0, 0, 6'h0, 32'h0);
        wr(6'h1C, 32'h3);
        send(a_addr, 16'd64, "R2 packing slot0", 0, 0, 6'h0, 32'h0);
        send(b_addr, 16'd64, "R2 packing slot1", 0, 0, 6'h0, 32'h0);

        // R4: broadcast
        wr(6'h1C, 32'h8);
        send({48{1'b1}}, 16'd64, "R4 bcast on", 0, 0, 6'h0, 32'h0);
        wr(6'h1C, 32'h0);
        send({48{1'b1}}, 16'd64, "R4 bcast off", 0, 0, 6'h0, 32'h0);

        // R7: length boundary
        wr(6'h1C, 32'h1);
        send(a_addr, 16'd11, "R7 len 11 dropped", 0, 0, 6'h0, 32'h0);
        send(a_addr, 16'd12, "R7 len 12 accepted", 0, 0, 6'h0, 32'h0);

        // R8: gaps and trailing octets
        send(a_addr, 16'd64, "R8 gapped frame", 1, 0, 6'h0, 32'h0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            oct_valid = 1'b1; oct_first = 1'b0; oct_data = 8'h77;
            check(verdict_valid == 1'b0, "R8 trailing octet", 64'(verdict_valid), 64'd0);
        end
        @(negedge clk);
        oct_valid = 1'b0;
        check(verdict_valid == 1'b0, "R8 trailing octet", 64'(verdict_valid), 64'd0);

        // R10: partial frame then restart
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            oct_valid = 1'b1; oct_first = (i == 0); oct_data = 8'hEE; frame_len = 16'd64;
        end
        @(negedge clk);
        oct_valid = 1'b0;
        check(verdict_valid == 1'b0, "R10 partial no verdict", 64'(verdict_valid), 64'd0);
        send(a_addr, 16'd64, "R10 restarted frame", 0, 0, 6'h0, 32'h0);

        // R9: write mid-frame affects next frame only
        wr(6'h1C, 32'h8);
        send({48{1'b1}}, 16'd64, "R9 old config in flight", 0, 1, 6'h1C, 32'h0);
        send({48{1'b1}}, 16'd64, "R9 new config next frame", 0, 0, 6'h0, 32'h0);

        // R5: one-hot table sweep over all 64 indices
        wr(6'h1C, 32'h4);
        for (int idx = 0; idx < 64; idx++) begin
            wr(6'h10, idx < 32 ? (32'h1 << idx) : 32'h0);
            wr(6'h14, idx >= 32 ? (32'h1 << (idx - 32)) : 32'h0);
            send(48'(idx), 16'd64, "R5 one-hot hit", 0, 0, 6'h0, 32'h0);
            send(48'(idx ^ 1), 16'd64, "R5 one-hot neighbour miss", 0, 0, 6'h0, 32'h0);
        end

        // R5 R6: dense table, varied destinations, indiv gate clear and set
        wr(6'h10, 32'h1E78_D24B);
        wr(6'h14, 32'hA5C3_0F96);
        for (int pass = 0; pass < 2; pass++) begin
            wr(6'h1C, pass == 0 ? 32'h0 : 32'h4);
            for (int i = 0; i < 256; i++) begin
                d = {8'(i * 7 + 3), 8'(i ^ 8'hC5), 8'(i * 13), 8'(~i), 8'(i + 8'h21), 8'(i)};
                send(d, 16'd64, pass == 0 ? "R6 gate clear sweep" : "R5 gate set sweep",
                     0, 0, 6'h0, 32'h0);
            end
        end

        finish_run();
    end

endmodule